// File: doc/BRIEF.md
# Automatic stereo sample write engine

This block serves one core of a sound processor while that core runs in automatic write mode. It pulls 16-bit sample words from a show-ahead input FIFO, at most one per clock. Each word goes to a halfword-addressed sound memory. The input stream alternates between a run of 256 left-channel words and a run of 256 right-channel words. Every word of the left run is written below a fixed left base address, and every word of the right run below a fixed right base address. The offset within the run is added to that base.

A running transfer count picks the run and the offset. At the end of every run the engine does four things: it raises its need-data flag, tells the feeding DMA channel to stop, posts that channel's completion interrupt, and clears its own enable bit in the status register. No further words are taken until software sets that bit again. A small register port holds a two-bit mode field and the status register.

Top module: `adma_write_engine`

## Requirements
- R1: After reset, the mode field, the status register and the transfer count are 0, and mem_we, need_data, fifo_rd, chan_stop and chan_irq_set are all low.
- R2: cfg_sel=0 selects the mode field, held in cfg_wdata[1:0]. The codes are 0 auto write, 1 auto read, 2 manual write and 3 manual read. Words are drained only when the mode is 0; the other codes cause no pop and no write.
- R3: cfg_sel=1 selects the status register. The engine is enabled only when the status value ANDed with (CORE_ID+1) is nonzero.
- R4: When the engine is enabled and fifo_empty is high, there is no pop and no write, and need_data is high in the next cycle.
- R5: When the engine is enabled and the FIFO holds a word, fifo_rd is high in that same cycle. In the next cycle mem_we is high, mem_wdata carries that word and need_data is low, unless the word closes a run.
- R6: For a write, count bit 8 (the count before the increment) selects the base: 0 for LEFT_BASE, 1 for RIGHT_BASE. Count bits 7:0 are added to that base as the offset.
- R7: The write address wraps modulo 2^ADDR_W, which is 0x100000 halfwords by default.
- R8: Every written word adds exactly one to xfer_count, and no other event changes it.
- R9: When a write brings the count to a multiple of 256, chan_stop and chan_irq_set pulse for one cycle together with that write. In the same cycle need_data is high and the status bits under (CORE_ID+1) read back as 0.
- R10: After a run ends, no word is drained until software writes the enable bit again, even while the FIFO holds data.
- R11: cfg_rdata returns the selected register with no delay: the mode field in bits 1:0 with zeros above it, or the full status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 selects mode, 1 selects status |
| cfg_wdata | input | STAT_W | Register write data |
| cfg_rdata | output | STAT_W | Selected register value |
| fifo_empty | input | 1 | Input FIFO has no word |
| fifo_data | input | DATA_W | Head word of the input FIFO |
| fifo_rd | output | 1 | Pop the head word this cycle |
| mem_we | output | 1 | Sound memory write strobe |
| mem_addr | output | ADDR_W | Halfword write address |
| mem_wdata | output | DATA_W | Write data |
| need_data | output | 1 | Engine is waiting for data |
| xfer_count | output | COUNT_W | Words written since reset |
| chan_stop | output | 1 | Clear the feeding DMA channel's start bit |
| chan_irq_set | output | 1 | Set the feeding channel's completion flag |

## Verification
A wrong transfer count shows up on the next write: the address lands in the wrong run or at the wrong offset, and the end-of-run pulses come at the wrong word. The per-clock reference comparison catches that within one cycle. A stuck enable or mode bit shows up at once as a pop or a missing pop on fifo_rd. A misplaced run boundary is exposed by the status readback and by the words left in the FIFO after the stop.

// File: rtl/adma_pkg.sv
package adma_pkg;
   typedef enum logic [1:0] {
      MODE_AUTO_WR = 2'd0,
      MODE_AUTO_RD = 2'd1,
      MODE_MAN_WR  = 2'd2,
      MODE_MAN_RD  = 2'd3
   } adma_mode_e;

   localparam logic SEL_MODE = 1'b0;
   localparam logic SEL_STAT = 1'b1;
endpackage

// File: rtl/adma_cfg_regs.sv
module adma_cfg_regs
   import adma_pkg::*;
#(
   parameter int unsigned STAT_W  = 16,
   parameter int unsigned CORE_ID = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic              cfg_sel,
   input  logic [STAT_W-1:0] cfg_wdata,
   input  logic              eng_off,
   output logic [STAT_W-1:0] cfg_rdata,
   output logic              enabled
);
   localparam logic [STAT_W-1:0] CORE_MASK = STAT_W'(CORE_ID + 1);

   adma_mode_e        mode_q;
   logic [STAT_W-1:0] stat_q;
   logic [STAT_W-1:0] stat_d;

   always_comb begin
      stat_d = (cfg_wr && cfg_sel == SEL_STAT) ? cfg_wdata : stat_q;
      if (eng_off) stat_d = stat_d & ~CORE_MASK;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= MODE_AUTO_WR;
         stat_q <= '0;
      end else begin
         if (cfg_wr && cfg_sel == SEL_MODE) mode_q <= adma_mode_e'(cfg_wdata[1:0]);
         stat_q <= stat_d;
      end
   end

   assign enabled   = (mode_q == MODE_AUTO_WR) && ((stat_q & CORE_MASK) != '0);
   assign cfg_rdata = (cfg_sel == SEL_STAT) ? stat_q : {{(STAT_W-2){1'b0}}, mode_q};

   // R10: an end-of-run request leaves the core bit clear on the next cycle
   a_r10_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
      eng_off |=> ((stat_q & CORE_MASK) == '0));
endmodule

// File: rtl/adma_xfer_ctrl.sv
module adma_xfer_ctrl #(
   parameter int unsigned COUNT_W    = 16,
   parameter int unsigned BLOCK_LOG2 = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               active,
   input  logic               fifo_empty,
   output logic               take,
   output logic               eng_off,
   output logic [COUNT_W-1:0] count,
   output logic               need_data,
   output logic               blk_end
);
   logic last_in_blk;

   assign take        = active && !fifo_empty;
   assign last_in_blk = &count[BLOCK_LOG2-1:0];
   assign eng_off     = take && last_in_blk;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count     <= '0;
         need_data <= 1'b0;
         blk_end   <= 1'b0;
      end else begin
         blk_end <= eng_off;
         if (take) count <= count + 1'b1;
         if (active) need_data <= fifo_empty ? 1'b1 : last_in_blk;
      end
   end

   // R4: an empty FIFO while enabled raises need_data
   a_r4_empty_need: assert property (@(posedge clk) disable iff (!rst_n)
      (active && fifo_empty) |=> need_data);
endmodule

// File: rtl/adma_mem_writer.sv
module adma_mem_writer #(
   parameter int unsigned ADDR_W     = 20,
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned BLOCK_LOG2 = 8,
   parameter int unsigned LEFT_BASE  = 32'h0_2000,
   parameter int unsigned RIGHT_BASE = 32'hF_FF80
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic [BLOCK_LOG2:0] blk_pos,
   input  logic [DATA_W-1:0] din,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata
);
   localparam logic [ADDR_W-1:0] L_BASE = ADDR_W'(LEFT_BASE);
   localparam logic [ADDR_W-1:0] R_BASE = ADDR_W'(RIGHT_BASE);
   localparam bit ALIGNED = ((LEFT_BASE  % (32'd1 << BLOCK_LOG2)) == 0) &&
                            ((RIGHT_BASE % (32'd1 << BLOCK_LOG2)) == 0);

   logic [ADDR_W-1:0]     base;
   logic [BLOCK_LOG2-1:0] offs;
   logic [ADDR_W-1:0]     addr_d;

   assign base = blk_pos[BLOCK_LOG2] ? R_BASE : L_BASE;
   assign offs = blk_pos[BLOCK_LOG2-1:0];

   generate
      if (ALIGNED) begin : g_concat
         assign addr_d = {base[ADDR_W-1:BLOCK_LOG2], offs};
      end else begin : g_adder
         assign addr_d = base + ADDR_W'(offs);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem_we    <= 1'b0;
         mem_addr  <= '0;
         mem_wdata <= '0;
      end else begin
         mem_we <= take;
         if (take) begin
            mem_addr  <= addr_d;
            mem_wdata <= din;
         end
      end
   end

   // R5: the write data holds still between writes
   a_r5_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we |-> $stable(mem_wdata));
endmodule

// File: rtl/adma_write_engine.sv
module adma_write_engine #(
   parameter int unsigned ADDR_W     = 20,
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned STAT_W     = 16,
   parameter int unsigned COUNT_W    = 16,
   parameter int unsigned BLOCK_LOG2 = 8,
   parameter int unsigned CORE_ID    = 0,
   parameter int unsigned LEFT_BASE  = 32'h0_2000,
   parameter int unsigned RIGHT_BASE = 32'hF_FF80
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_wr,
   input  logic               cfg_sel,
   input  logic [STAT_W-1:0]  cfg_wdata,
   output logic [STAT_W-1:0]  cfg_rdata,
   input  logic               fifo_empty,
   input  logic [DATA_W-1:0]  fifo_data,
   output logic               fifo_rd,
   output logic               mem_we,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic [DATA_W-1:0]  mem_wdata,
   output logic               need_data,
   output logic [COUNT_W-1:0] xfer_count,
   output logic               chan_stop,
   output logic               chan_irq_set
);
   generate
      if (COUNT_W <= BLOCK_LOG2) begin : g_bad_count
         $error("COUNT_W must exceed BLOCK_LOG2");
      end
      if (ADDR_W <= BLOCK_LOG2) begin : g_bad_addr
         $error("ADDR_W must exceed BLOCK_LOG2");
      end
      if (STAT_W < 2 || (CORE_ID + 1) >= (1 << STAT_W)) begin : g_bad_stat
         $error("STAT_W too narrow for mode field or core mask");
      end
      if (BLOCK_LOG2 < 1) begin : g_bad_blk
         $error("BLOCK_LOG2 must be at least 1");
      end
   endgenerate

   logic enabled;
   logic take;
   logic eng_off;
   logic blk_end;

   adma_cfg_regs #(.STAT_W(STAT_W), .CORE_ID(CORE_ID)) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .eng_off(eng_off), .cfg_rdata(cfg_rdata),
      .enabled(enabled)
   );

   adma_xfer_ctrl #(.COUNT_W(COUNT_W), .BLOCK_LOG2(BLOCK_LOG2)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .active(enabled), .fifo_empty(fifo_empty),
      .take(take), .eng_off(eng_off), .count(xfer_count),
      .need_data(need_data), .blk_end(blk_end)
   );

   adma_mem_writer #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLOCK_LOG2(BLOCK_LOG2),
      .LEFT_BASE(LEFT_BASE), .RIGHT_BASE(RIGHT_BASE)
   ) u_wr (
      .clk(clk), .rst_n(rst_n), .take(take),
      .blk_pos(xfer_count[BLOCK_LOG2:0]), .din(fifo_data),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
   );

   assign fifo_rd      = take;
   assign chan_stop    = blk_end;
   assign chan_irq_set = blk_end;

   // R5: never pop an empty FIFO
   a_r5_pop_ready: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_rd |-> !fifo_empty);
   // R8: each write is matched by a count step of one
   a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (xfer_count == COUNT_W'($past(xfer_count) + 1'b1)));
   // R9: end-of-run pulse coincides with a write and need_data
   a_r9_stop_with_write: assert property (@(posedge clk) disable iff (!rst_n)
      chan_stop |-> (mem_we && need_data));
   // R9: the pulse lasts one cycle
   a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      chan_stop |=> !chan_stop);
   // R10: the engine is halted once a run has ended
   a_r10_halted: assert property (@(posedge clk) disable iff (!rst_n)
      chan_stop |-> !enabled);
endmodule

// File: tb/tb_adma_write_engine.sv
module tb_adma_write_engine;
   localparam int LB = 32'h0_2000;
   localparam int RB = 32'hF_FF80;
   localparam int CMASK = 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic        cfg_sel = 1'b0;
   logic [15:0] cfg_wdata = '0;
   logic [15:0] cfg_rdata;
   logic        fifo_empty = 1'b1;
   logic [15:0] fifo_data = '0;
   logic        fifo_rd, mem_we, need_data, chan_stop, chan_irq_set;
   logic [19:0] mem_addr;
   logic [15:0] mem_wdata, xfer_count;

   always #4 clk = ~clk;

   adma_write_engine dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .fifo_empty(fifo_empty),
      .fifo_data(fifo_data), .fifo_rd(fifo_rd), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .need_data(need_data),
      .xfer_count(xfer_count), .chan_stop(chan_stop), .chan_irq_set(chan_irq_set)
   );

   int total = 0;
   int bad = 0;
   bit checking = 0;
   logic [15:0] fq[$];
   bit pend_pop = 0;
   int next_word = 16'h1357;
   int wraps = 0;

   int m_mode, m_status, m_count, m_addr, m_wdata;
   bit m_need, m_we, m_stop;

   task automatic check(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // reference model
   always @(posedge clk) begin
      if (!rst_n) begin
         m_mode = 0; m_status = 0; m_count = 0; m_need = 0;
         m_we = 0; m_stop = 0; m_addr = 0; m_wdata = 0;
      end else begin
         bit act;
         int nstat;
         act = (m_mode == 0) && ((m_status & CMASK) != 0);
         m_we = 0; m_stop = 0;
         nstat = (cfg_wr && cfg_sel) ? int'(cfg_wdata) : m_status;
         if (cfg_wr && !cfg_sel) m_mode = cfg_wdata & 3;
         if (act) begin
            if (fifo_empty) m_need = 1;
            else begin
               int blk;
               blk = (m_count >> 8) & 1;
               m_we = 1;
               m_wdata = fifo_data;
               m_addr = ((blk ? RB : LB) + (m_count & 255)) & 32'hFFFFF;
               if (blk && m_addr < RB) wraps++;
               m_count = (m_count + 1) & 16'hFFFF;
               m_need = 0;
               pend_pop = 1;
               if (m_count % 256 == 0) begin
                  m_need = 1; m_stop = 1; nstat = nstat & ~CMASK;
               end
            end
         end
         m_status = nstat;
      end
   end

   // FIFO driver
   always @(negedge clk) begin
      if (pend_pop) begin
         void'(fq.pop_front());
         pend_pop = 0;
      end
      #1;
      fifo_empty = (fq.size() == 0);
      fifo_data  = (fq.size() == 0) ? 16'h0 : fq[0];
   end

   // per-cycle comparison
   always @(negedge clk) begin
      #3;
      if (checking) begin
         bit exp_rd;
         exp_rd = (m_mode == 0) && ((m_status & CMASK) != 0) && !fifo_empty;
         check("R5 fifo_rd", fifo_rd, exp_rd);
         check("R5 mem_we", mem_we, m_we);
         if (m_we) begin
            check("R6 mem_addr", mem_addr, m_addr);
            check("R5 mem_wdata", mem_wdata, m_wdata);
         end
         check("R4 need_data", need_data, m_need);
         check("R8 xfer_count", xfer_count, m_count);
         check("R9 chan_stop", chan_stop, m_stop);
         check("R9 chan_irq_set", chan_irq_set, m_stop);
         check("R11 cfg_rdata", cfg_rdata, cfg_sel ? m_status : m_mode);
      end
   end

   task automatic push(int n);
      for (int i = 0; i < n; i++) begin
         fq.push_back(16'(next_word));
         next_word = (next_word * 5 + 17) & 16'hFFFF;
      end
   endtask

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
      #3;
   endtask

   task automatic cfg_write(bit sel, int val);
      @(negedge clk);
      cfg_wr = 1; cfg_sel = sel; cfg_wdata = 16'(val);
      @(negedge clk);
      cfg_wr = 0;
   endtask

   initial begin
      #(8 * 150000);
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1;
      cfg_sel = 1;
      #3;
      check("R1 mem_we", mem_we, 0);
      check("R1 need_data", need_data, 0);
      check("R1 xfer_count", xfer_count, 0);
      check("R1 chan_stop", chan_stop, 0);
      check("R1 status", cfg_rdata, 0);
      checking = 1;

      push(5);
      cyc(4);
      check("R3 idle with status 0", xfer_count, 0);
      cfg_write(1, 2);
      cyc(4);
      check("R3 wrong core bit", xfer_count, 0);
      cfg_write(0, 2);
      cfg_write(1, 1);
      cyc(4);
      check("R2 manual mode no drain", xfer_count, 0);
      cfg_write(0, 1);
      cyc(4);
      check("R2 auto read no drain", xfer_count, 0);
      cfg_write(0, 0);
      cyc(10);
      check("R8 five words", xfer_count, 5);
      check("R4 empty sets need", need_data, 1);

      push(255);
      cyc(300);
      check("R9 run end count", xfer_count, 256);
      cfg_sel = 1;
      cyc(1);
      check("R9 core bit cleared", cfg_rdata & CMASK, 0);
      check("R10 words left", fq.size(), 4);
      cyc(20);
      check("R10 still halted", xfer_count, 256);

      cfg_write(1, 1);
      for (int k = 0; k < 6; k++) begin
         push(20);
         cyc(25);
      end
      push(140);
      cyc(200);
      check("R9 second run end", xfer_count, 512);
      check("R7 wrapped writes", wraps > 0, 1);
      cfg_write(1, 1);
      cyc(20);
      check("R6 left run resumed", xfer_count, 520);

      checking = 0;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule